// File: doc/BRIEF.md
# Banked Analog-Output Card Register Interface

This block is the register front end of a multi-channel analog output card on a 16-bit I/O port bus. The host presents a word index `bus_addr` (the byte offset within a 32-byte window, divided by two) together with a one-cycle write or read strobe. The block holds three configuration words, an 8-bit digital port latch whose drivers are enabled a nibble at a time, and a read-only status word assembled from flag inputs. It also produces registered strobes toward the DAC channels, the FIFO and the interrupt/DMA logic.

One bit in the first configuration word chooses between two register banks. In the first bank the low addresses write the digital port and two configuration words, and word 6 pushes into the FIFO. In the second bank the same low addresses emit one-cycle clear pulses for the DMA terminal count, interrupt 1 and interrupt 2, and word 6 loads DAC channel 0. The DAC converters, FIFO storage, counter/timer and serial PROM are outside the block. They appear only as strobe outputs and flag inputs.

Top module: `aoboard_regif`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `cfg1_q`, `cfg2_q`, `cfg3_q`, `dio_out`, `dio_oe`, `dac_data`, `fifo_data` and every pulse output are zero. Zero in `cfg1_q` bit 7 means bank 1 is selected.
- R2: A write to word 5 (byte 0x0a) loads `cfg1_q` from `bus_wdata` in either bank, and `cfg1_q` bit 7 selects bank 2. A read of word 5 returns the status in bits 6..0: bit 6 `fifo_half`, bit 5 `fifo_empty`, bit 4 `fifo_full`, bit 3 `int2_flag`, bit 2 `int1_flag`, bit 1 `tc_flag`, bit 0 `prom_bit`. The upper bits read zero. Words 1..4 and 7..15 read as zero.
- R3: In bank 1, writes to words 0, 1 and 2 load `dio_out` (from `bus_wdata[7:0]`), `cfg2_q` and `cfg3_q` respectively, and raise none of `dmatc_clr`, `int1_clr` or `int2_clr`.
- R4: In bank 2, writes to words 0, 1 and 2 raise `dmatc_clr`, `int1_clr` and `int2_clr` respectively for exactly the cycle after the write. `dio_out`, `cfg2_q` and `cfg3_q` stay unchanged.
- R5: `dio_oe[3:0]` all equal `cfg3_q` bit 2 and `dio_oe[7:4]` all equal `cfg3_q` bit 3. A read of word 0 returns `dio_pins` zero-extended in either bank.
- R6: A write to word 6+x, for 1 <= x < NUM_CH, in either bank raises `dac_load[x]` for the next cycle only. From that cycle on, `dac_data` holds `bus_wdata[11:0]`, which passes through unchanged as a two's-complement code.
- R7: A write to word 6 in bank 2 raises `dac_load[0]` and updates `dac_data`. In bank 1 it instead raises `fifo_push` for one cycle with `fifo_data` = `bus_wdata`, and no DAC load occurs.
- R8: A read of word 6 raises `fifo_clr` for exactly the next cycle and returns zero. No other access raises `fifo_clr`.
- R9: Writes to words at or above 6+NUM_CH (with the default of 6 channels, words 12..15) raise no pulse and leave `dac_data` and all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Word index within the window |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for the current address |
| dio_pins | input | DIO_W (8) | Sensed state of the digital port pins |
| dio_out | output | DIO_W (8) | Digital port output latch |
| dio_oe | output | DIO_W (8) | Per-pin driver enable |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| int2_flag | input | 1 | Interrupt 2 pending |
| int1_flag | input | 1 | Interrupt 1 pending |
| tc_flag | input | 1 | Terminal-count interrupt pending |
| prom_bit | input | 1 | Serial PROM data out |
| cfg1_q | output | DATA_W (16) | Configuration word 1 (bank select in bit 7) |
| cfg2_q | output | DATA_W (16) | Configuration word 2 |
| cfg3_q | output | DATA_W (16) | Configuration word 3 |
| dac_load | output | NUM_CH (6) | One-cycle load strobe per DAC channel |
| dac_data | output | DAC_W (12) | Last DAC code written |
| fifo_push | output | 1 | One-cycle FIFO write strobe |
| fifo_data | output | DATA_W (16) | Last FIFO word written |
| fifo_clr | output | 1 | One-cycle FIFO clear strobe |
| dmatc_clr | output | 1 | One-cycle DMA terminal-count clear |
| int1_clr | output | 1 | One-cycle interrupt 1 clear |
| int2_clr | output | 1 | One-cycle interrupt 2 clear |

## Verification
The assertions assume the host never raises `bus_wr` and `bus_rd` in the same cycle. Under that assumption at most one of the pulse outputs can be high in any cycle, and every pulse follows from the single access in the cycle before it. The stimulus keeps to this rule. Each operation, whether directed or random, is an idle, a write or a read, never two at once. The random operations also write word 5 now and then, so the bank flips while clear-pulse, DAC and FIFO addresses are being hit.

// File: rtl/aoregs_pkg.sv
package aoregs_pkg;

    // bit positions that other logic decodes
    localparam int BANK_BIT  = 7;
    localparam int OE_LO_BIT = 2;
    localparam int OE_HI_BIT = 3;

    // fixed word indices in the window
    localparam int W_DIO  = 0;
    localparam int W_CFG2 = 1;
    localparam int W_CFG3 = 2;
    localparam int W_CFG1 = 5;
    localparam int W_DAC0 = 6;

    typedef struct packed {
        logic       dio_wr;
        logic       cfg1_wr;
        logic       cfg2_wr;
        logic       cfg3_wr;
        logic       tc_clr;
        logic       i1_clr;
        logic       i2_clr;
        logic       push;
        logic       fclr;
        logic       dac_hit;
        logic [3:0] dac_idx;
    } acc_t;

endpackage

// File: rtl/aoregs_decode.sv
module aoregs_decode
    import aoregs_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              bank2,
    output acc_t              acc
);

    int widx;

    always_comb begin
        acc  = '0;
        widx = int'(addr);
        case (widx)
            W_DIO: begin
                if (wr) begin
                    if (bank2) acc.tc_clr = 1'b1;
                    else       acc.dio_wr = 1'b1;
                end
            end
            W_CFG2: begin
                if (wr) begin
                    if (bank2) acc.i1_clr  = 1'b1;
                    else       acc.cfg2_wr = 1'b1;
                end
            end
            W_CFG3: begin
                if (wr) begin
                    if (bank2) acc.i2_clr  = 1'b1;
                    else       acc.cfg3_wr = 1'b1;
                end
            end
            W_CFG1: begin
                if (wr) acc.cfg1_wr = 1'b1;
            end
            W_DAC0: begin
                if (wr) begin
                    if (bank2) begin
                        acc.dac_hit = 1'b1;
                        acc.dac_idx = 4'd0;
                    end else begin
                        acc.push = 1'b1;
                    end
                end
                if (rd) acc.fclr = 1'b1;
            end
            default: begin
                if (wr && widx > W_DAC0 && widx < W_DAC0 + NUM_CH) begin
                    acc.dac_hit = 1'b1;
                    acc.dac_idx = 4'(widx - W_DAC0);
                end
            end
        endcase
    end

endmodule

// File: rtl/aoregs_regs.sv
module aoregs_regs
    import aoregs_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 16,
    parameter int DAC_W  = 12,
    parameter int DIO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg1_q,
    output logic [DATA_W-1:0] cfg2_q,
    output logic [DATA_W-1:0] cfg3_q,
    output logic [DIO_W-1:0]  dio_q,
    output logic [NUM_CH-1:0] load_q,
    output logic [DAC_W-1:0]  dac_q,
    output logic [DATA_W-1:0] fifo_q,
    output logic              push_q,
    output logic              fclr_q,
    output logic              tclr_q,
    output logic              i1clr_q,
    output logic              i2clr_q
);

    typedef struct packed {
        logic [DATA_W-1:0] cfg1;
        logic [DATA_W-1:0] cfg2;
        logic [DATA_W-1:0] cfg3;
        logic [DATA_W-1:0] fifo;
        logic [DIO_W-1:0]  dio;
        logic [DAC_W-1:0]  dac;
        logic [NUM_CH-1:0] load;
        logic              push;
        logic              fclr;
        logic              tclr;
        logic              i1clr;
        logic              i2clr;
    } st_t;

    st_t               st_d, st_q;
    logic [NUM_CH-1:0] load_sel_d;

    // one select per DAC channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ldsel
        assign load_sel_d[g] = acc.dac_hit && (acc.dac_idx == 4'(g));
    end

    always_comb begin
        st_d       = st_q;
        st_d.load  = load_sel_d;
        st_d.push  = acc.push;
        st_d.fclr  = acc.fclr;
        st_d.tclr  = acc.tc_clr;
        st_d.i1clr = acc.i1_clr;
        st_d.i2clr = acc.i2_clr;
        if (acc.cfg1_wr) st_d.cfg1 = wdata;
        if (acc.cfg2_wr) st_d.cfg2 = wdata;
        if (acc.cfg3_wr) st_d.cfg3 = wdata;
        if (acc.dio_wr)  st_d.dio  = wdata[DIO_W-1:0];
        if (acc.push)    st_d.fifo = wdata;
        if (acc.dac_hit) st_d.dac  = wdata[DAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg1_q  = st_q.cfg1;
    assign cfg2_q  = st_q.cfg2;
    assign cfg3_q  = st_q.cfg3;
    assign dio_q   = st_q.dio;
    assign load_q  = st_q.load;
    assign dac_q   = st_q.dac;
    assign fifo_q  = st_q.fifo;
    assign push_q  = st_q.push;
    assign fclr_q  = st_q.fclr;
    assign tclr_q  = st_q.tclr;
    assign i1clr_q = st_q.i1clr;
    assign i2clr_q = st_q.i2clr;

endmodule

// File: rtl/aoregs_rdmux.sv
module aoregs_rdmux
    import aoregs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIO_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DIO_W-1:0]  pins,
    input  logic [6:0]        status,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (int'(addr))
            W_DIO:   rdata[DIO_W-1:0] = pins;
            W_CFG1:  rdata[6:0]       = status;
            default: rdata            = '0;
        endcase
    end

endmodule

// File: rtl/aoboard_regif.sv
module aoboard_regif
    import aoregs_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 16,
    parameter int DAC_W  = 12,
    parameter int DIO_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DIO_W-1:0]  dio_pins,
    output logic [DIO_W-1:0]  dio_out,
    output logic [DIO_W-1:0]  dio_oe,
    input  logic              fifo_half,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic              int2_flag,
    input  logic              int1_flag,
    input  logic              tc_flag,
    input  logic              prom_bit,
    output logic [DATA_W-1:0] cfg1_q,
    output logic [DATA_W-1:0] cfg2_q,
    output logic [DATA_W-1:0] cfg3_q,
    output logic [NUM_CH-1:0] dac_load,
    output logic [DAC_W-1:0]  dac_data,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_clr,
    output logic              dmatc_clr,
    output logic              int1_clr,
    output logic              int2_clr
);

    localparam int HALF_DIO = DIO_W / 2;

    acc_t       acc;
    logic [6:0] status;

    assign status = {fifo_half, fifo_empty, fifo_full,
                     int2_flag, int1_flag, tc_flag, prom_bit};

    aoregs_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .bank2 (cfg1_q[BANK_BIT]),
        .acc   (acc)
    );

    aoregs_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .DAC_W  (DAC_W),
        .DIO_W  (DIO_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wdata   (bus_wdata),
        .cfg1_q  (cfg1_q),
        .cfg2_q  (cfg2_q),
        .cfg3_q  (cfg3_q),
        .dio_q   (dio_out),
        .load_q  (dac_load),
        .dac_q   (dac_data),
        .fifo_q  (fifo_data),
        .push_q  (fifo_push),
        .fclr_q  (fifo_clr),
        .tclr_q  (dmatc_clr),
        .i1clr_q (int1_clr),
        .i2clr_q (int2_clr)
    );

    aoregs_rdmux #(
        .DATA_W (DATA_W),
        .DIO_W  (DIO_W),
        .ADDR_W (ADDR_W)
    ) u_rdmux (
        .addr   (bus_addr),
        .pins   (dio_pins),
        .status (status),
        .rdata  (bus_rdata)
    );

    // driver enables, one nibble-wide group per config bit
    for (genvar g = 0; g < DIO_W; g++) begin : g_oe
        if (g < HALF_DIO) begin : g_lo
            assign dio_oe[g] = cfg3_q[OE_LO_BIT];
        end else begin : g_hi
            assign dio_oe[g] = cfg3_q[OE_HI_BIT];
        end
    end

endmodule

// File: rtl/aoregs_chk.sv
module aoregs_chk #(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 16,
    parameter int DIO_W  = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] cfg1_q,
    input logic [DATA_W-1:0] cfg2_q,
    input logic [DATA_W-1:0] cfg3_q,
    input logic [DIO_W-1:0]  dio_out,
    input logic [NUM_CH-1:0] dac_load,
    input logic              fifo_clr,
    input logic              fifo_push,
    input logic              dmatc_clr,
    input logic              int1_clr,
    input logic              int2_clr
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cfg1_q == '0 && cfg2_q == '0 && cfg3_q == '0 && dio_out == '0)); // R1

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmatc_clr, int1_clr, int2_clr, fifo_clr, fifo_push, dac_load})); // R4

    AST_BANK2_TC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 0 && cfg1_q[7] |=> dmatc_clr && $stable(dio_out)); // R4

    AST_BANK2_INT1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 1 && cfg1_q[7] |=> int1_clr && $stable(cfg2_q)); // R4

    AST_BANK2_INT2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 2 && cfg1_q[7] |=> int2_clr && $stable(cfg3_q)); // R4

    AST_BANK1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr < 3 && !cfg1_q[7] |=> !dmatc_clr && !int1_clr && !int2_clr); // R3

    AST_FIFO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 6 |=> fifo_clr); // R8

    AST_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |-> $past(bus_rd) && $past(bus_addr) == 6); // R8

    AST_WORD6_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 6 && !cfg1_q[7] |=> fifo_push && !dac_load[0]); // R7

    AST_DAC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && int'(bus_addr) >= 6 + NUM_CH |=> dac_load == '0); // R9

endmodule

bind aoboard_regif aoregs_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .DIO_W  (DIO_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/aoboard_regif_tb.sv
`timescale 1ns/1ps
module aoboard_regif_tb;

    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  dio_pins = '0;
    logic [7:0]  dio_out, dio_oe;
    logic        fifo_half = 0, fifo_empty = 0, fifo_full = 0;
    logic        int2_flag = 0, int1_flag = 0, tc_flag = 0, prom_bit = 0;
    logic [15:0] cfg1_q, cfg2_q, cfg3_q;
    logic [NCH-1:0] dac_load;
    logic [11:0] dac_data;
    logic        fifo_push, fifo_clr, dmatc_clr, int1_clr, int2_clr;
    logic [15:0] fifo_data;

    always #2 clk = ~clk;

    aoboard_regif #(.NUM_CH(NCH)) u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference
    logic [15:0] m_cfg1, m_cfg2, m_cfg3, m_fifo;
    logic [7:0]  m_dio;
    logic [11:0] m_dac;
    int          m_load;
    bit          m_push, m_fclr, m_tclr, m_i1, m_i2;

    always @(posedge clk) begin
        int w;
        bit bank;
        w = int'(bus_addr);
        bank = m_cfg1[7];
        m_load = 0; m_push = 0; m_fclr = 0; m_tclr = 0; m_i1 = 0; m_i2 = 0;
        if (!rst_n) begin
            m_cfg1 = 0; m_cfg2 = 0; m_cfg3 = 0; m_fifo = 0; m_dio = 0; m_dac = 0;
        end else if (bus_wr) begin
            if (w == 5) m_cfg1 = bus_wdata;
            else if (w == 0) begin if (bank) m_tclr = 1; else m_dio = bus_wdata[7:0]; end
            else if (w == 1) begin if (bank) m_i1 = 1; else m_cfg2 = bus_wdata; end
            else if (w == 2) begin if (bank) m_i2 = 1; else m_cfg3 = bus_wdata; end
            else if (w == 6) begin
                if (bank) begin m_load = 1; m_dac = bus_wdata[11:0]; end
                else begin m_push = 1; m_fifo = bus_wdata; end
            end else if (w > 6 && w - 6 < NCH) begin
                m_load = 1 << (w - 6);
                m_dac = bus_wdata[11:0];
            end
        end else if (bus_rd && w == 6) begin
            m_fclr = 1;
        end
    end

    function automatic logic [15:0] exp_rdata();
        case (int'(bus_addr))
            0: return {8'h00, dio_pins};
            5: return {9'h000, fifo_half, fifo_empty, fifo_full,
                       int2_flag, int1_flag, tc_flag, prom_bit};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(cfg1_q == m_cfg1, "R2 cfg1", cfg1_q, m_cfg1);
            chk(cfg2_q == m_cfg2, "R3 cfg2", cfg2_q, m_cfg2);
            chk(cfg3_q == m_cfg3, "R3 cfg3", cfg3_q, m_cfg3);
            chk(dio_out == m_dio, "R3 dio_out", dio_out, m_dio);
            chk(dio_oe == {{4{m_cfg3[3]}}, {4{m_cfg3[2]}}}, "R5 dio_oe", dio_oe,
                {{4{m_cfg3[3]}}, {4{m_cfg3[2]}}});
            chk(dmatc_clr == m_tclr, "R4 dmatc_clr", dmatc_clr, m_tclr);
            chk(int1_clr == m_i1, "R4 int1_clr", int1_clr, m_i1);
            chk(int2_clr == m_i2, "R4 int2_clr", int2_clr, m_i2);
            chk(int'(dac_load) == m_load, "R6 R9 dac_load", dac_load, m_load);
            chk(dac_data == m_dac, "R6 R9 dac_data", dac_data, m_dac);
            chk(fifo_push == m_push, "R7 fifo_push", fifo_push, m_push);
            chk(fifo_data == m_fifo, "R7 fifo_data", fifo_data, m_fifo);
            chk(fifo_clr == m_fclr, "R8 fifo_clr", fifo_clr, m_fclr);
            chk(bus_rdata == exp_rdata(), "R2 R5 R8 rdata", bus_rdata, exp_rdata());
        end
    end

    task automatic wr_op(input int a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1; bus_rd = 0;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd_op(input int a);
        @(posedge clk); #1;
        bus_addr = 4'(a); bus_rd = 1; bus_wr = 0;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: explicit reset-state check while held in reset
        @(negedge clk);
        chk(cfg1_q == 0 && cfg2_q == 0 && cfg3_q == 0 && dio_out == 0 && dio_oe == 0,
            "R1 reset state", {cfg1_q, cfg3_q}, 0);
        @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        chk(dac_load == 0 && fifo_clr == 0 && fifo_push == 0 && dmatc_clr == 0,
            "R1 pulses after release", {dac_load, fifo_clr, fifo_push}, 0);

        // bank 1 register writes (R3) and direction (R5)
        wr_op(2, 16'h0004);
        wr_op(0, 16'hBEA5);
        wr_op(1, 16'h1234);
        dio_pins = 8'h3C;
        rd_op(0);
        wr_op(2, 16'h0008);
        wr_op(2, 16'h000C);
        // bank 1 word 6 pushes into the FIFO (R7)
        wr_op(6, 16'hC0DE);
        // switch to bank 2 (R2)
        wr_op(5, 16'h0080);
        wr_op(0, 16'hFFFF);   // R4 terminal-count clear
        wr_op(1, 16'hFFFF);   // R4 interrupt 1 clear
        wr_op(2, 16'hFFFF);   // R4 interrupt 2 clear
        wr_op(6, 16'h0FFF);   // R7 DAC channel 0
        wr_op(7, 16'h0800);   // R6 channel 1, most negative code
        wr_op(11, 16'h07FF);  // R6 last channel
        wr_op(12, 16'h0123);  // R9 beyond the last channel
        wr_op(15, 16'h0456);  // R9
        rd_op(6);             // R8 clear on read
        fifo_half = 1; fifo_full = 0; fifo_empty = 1; int2_flag = 1; prom_bit = 1;
        rd_op(5);             // R2 status
        dio_pins = 8'hC3;
        rd_op(0);             // R5 pins in bank 2
        wr_op(5, 16'h0000);   // back to bank 1
        wr_op(10, 16'h0ABC);  // R6 channel 4 from bank 1
        rd_op(3);

        // random mix, one access per cycle at most
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 3);
            dio_pins = 8'($urandom);
            {fifo_half, fifo_empty, fifo_full, int2_flag, int1_flag, tc_flag,
             prom_bit} = 7'($urandom);
            if (op == 1) wr_op(int'($urandom % 16), 16'($urandom));
            else if (op == 2) rd_op(int'($urandom % 16));
            else begin @(posedge clk); #1; end
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule